// File: doc/BRIEF.md
# Converter Calibration Sequencer and Word Correction

This block is the digital back end of a delta-sigma converter. It keeps a signed 24-bit offset word and an unsigned 24-bit gain word, and it runs self-calibration steps that fill them. It also turns every raw conversion word into a corrected word, computed as (raw - offset) scaled by gain. Software uses a small register port to start a calibration with a 3-bit command, to watch a done flag, and to read or write the offset, gain, setup and last-result registers. Raw words arrive with a valid bit. A conversion strobe marks the end of each conversion cycle, and a calibration step takes the word that is present on that strobe.

The sequencer is a five-state machine. `ST_IDLE` waits for a command. A command of 001 or 011 moves it to `ST_OFS_WAIT`, and a command of 010 moves it to `ST_GAIN_WAIT`. From `ST_OFS_WAIT`, a strobed sample loads the offset. The machine then goes to `ST_GAIN_WAIT` for a combined command, or to `ST_FINISH` otherwise. From `ST_GAIN_WAIT`, a strobed sample leads to `ST_DIVIDE` when the offset-corrected word is large enough to divide by. Otherwise the gain saturates and the machine goes to `ST_FINISH`. `ST_DIVIDE` produces one quotient bit per clock and goes to `ST_FINISH` after the last bit. `ST_FINISH` clears the command, sets the done flag and returns to `ST_IDLE`.

Top module: `adc_cal_core`

## Requirements
- R1: After reset the offset register reads 0x000000, the gain register reads 0x800000 (unity), the setup register reads 0, the configuration register reads 0, and `done_flag` and `cal_busy` are 0.
- R2: Register addresses are 0 configuration, 1 setup, 2 data, 3 offset and 4 gain. In the configuration register, bits [2:0] are the command and bit 3 is the read-only done flag. Setup bit 0 selects bipolar (1) or unipolar (0). Writes to setup, offset and gain take effect only while `cal_busy` is 0.
- R3: Command 001 stores the `raw_data` word present on the next cycle with `conv_strobe` and `raw_valid` both high into the offset register, as a signed value.
- R4: Command 010 takes the strobed sample s and forms d = s - offset. If d >= 0x400000, the gain becomes floor((2^23-1)*2^23 / d). Otherwise, including zero or negative d, the gain becomes 0xFFFFFF.
- R5: Command 011 runs the offset step on the first strobed sample, then the gain step on the second, using the new offset. `done_flag` stays 0 until the gain step ends.
- R6: When a calibration ends, the command field returns to 000 and `done_flag` becomes 1 on the same edge at which `cal_busy` falls.
- R7: A read of address 1, 2, 3 or 4 clears `done_flag`. A read of address 0 leaves it unchanged.
- R8: A configuration write while `cal_busy` is 1 is ignored. A write of code 000 or any code with bit 2 set starts nothing.
- R9: Each raw word with `raw_valid` high yields `out_valid` two clocks later, with out = floor((raw - offset) * gain / 2^23). Raw and offset are signed, gain is unsigned.
- R10: In bipolar mode the output saturates to the range [-2^23, 2^23-1]. In unipolar mode a negative result becomes 0 and the upper limit stays 2^23-1.
- R11: The data register returns the most recent corrected output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears done for addresses 1-4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data, combinational from `reg_addr` |
| conv_strobe | input | 1 | End of a conversion cycle |
| raw_valid | input | 1 | `raw_data` holds a conversion word |
| raw_data | input | 24 | Raw signed conversion word |
| out_valid | output | 1 | `out_data` holds a corrected word |
| out_data | output | 24 | Corrected, saturated word |
| cal_busy | output | 1 | A calibration is in progress |
| done_flag | output | 1 | Calibration finished and not yet acknowledged |

## Verification
The checker assumes three things about the inputs. `raw_valid` is low during reset. The setup mode bit does not change while a raw word is between the input and the output register. Consecutive strobed samples are at least one clock apart. The stimulus follows these rules: it drives every input on the falling edge, keeps each strobe and valid pulse to one clock with an idle clock after it, and changes the setup register only after the last output of a sample run has been observed.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFS_WAIT,
        ST_GAIN_WAIT,
        ST_DIVIDE,
        ST_FINISH
    } cal_state_t;

    localparam logic [2:0] CMD_NONE = 3'b000;
    localparam logic [2:0] CMD_OFS  = 3'b001;
    localparam logic [2:0] CMD_GAIN = 3'b010;
    localparam logic [2:0] CMD_BOTH = 3'b011;

    localparam logic [2:0] A_CFG   = 3'd0;
    localparam logic [2:0] A_SETUP = 3'd1;
    localparam logic [2:0] A_DATA  = 3'd2;
    localparam logic [2:0] A_OFS   = 3'd3;
    localparam logic [2:0] A_GAIN  = 3'd4;

endpackage

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
    import adc_cal_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   start_cmd,
    input  logic         take,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] offset_cur,
    output logic         busy,
    output logic         ofs_load,
    output logic         gain_load,
    output logic [W-1:0] gain_val,
    output logic         finish
);

    localparam int CNT_W = $clog2(W + 1);
    localparam logic [W-1:0] REM_INIT = {2'b00, {(W-2){1'b1}}};
    localparam logic [W-1:0] LOW_INIT = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MIN_DIV  = {2'b01, {(W-2){1'b0}}};

    cal_state_t state_q, state_d;
    logic             both_q;
    logic [W-1:0]     div_q, rem_q, quo_q, low_q;
    logic [CNT_W-1:0] cnt_q;

    logic signed [W:0] gdiff;
    logic              div_ok;
    logic [W:0]        trial, sub;
    logic              ge;
    logic              last_bit;

    assign gdiff    = $signed({sample[W-1], sample}) - $signed({offset_cur[W-1], offset_cur});
    assign div_ok   = !gdiff[W] && (gdiff[W-1:0] >= MIN_DIV);
    assign trial    = {rem_q, low_q[W-1]};
    assign sub      = trial - {1'b0, div_q};
    assign ge       = !sub[W];
    assign last_bit = (cnt_q == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (start_cmd == CMD_GAIN) state_d = ST_GAIN_WAIT;
                    else                       state_d = ST_OFS_WAIT;
                end
            end
            ST_OFS_WAIT: begin
                if (take) state_d = both_q ? ST_GAIN_WAIT : ST_FINISH;
            end
            ST_GAIN_WAIT: begin
                if (take) state_d = div_ok ? ST_DIVIDE : ST_FINISH;
            end
            ST_DIVIDE: begin
                if (last_bit) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        ofs_load  = 1'b0;
        gain_load = 1'b0;
        gain_val  = {quo_q[W-2:0], ge};
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE:      busy = 1'b0;
            ST_OFS_WAIT:  ofs_load = take;
            ST_GAIN_WAIT: begin
                gain_load = take && !div_ok;
                gain_val  = {W{1'b1}};
            end
            ST_DIVIDE:    gain_load = last_bit;
            ST_FINISH:    finish = 1'b1;
            default:      busy = 1'b0;
        endcase
    end

    // divider datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            both_q <= 1'b0;
            div_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            low_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start)
                both_q <= (start_cmd == CMD_BOTH);
            if (state_q == ST_GAIN_WAIT && take && div_ok) begin
                div_q <= gdiff[W-1:0];
                rem_q <= REM_INIT;
                low_q <= LOW_INIT;
                quo_q <= '0;
                cnt_q <= CNT_W'(W);
            end else if (state_q == ST_DIVIDE) begin
                rem_q <= ge ? sub[W-1:0] : trial[W-1:0];
                low_q <= {low_q[W-2:0], 1'b0};
                quo_q <= {quo_q[W-2:0], ge};
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/adc_cal_regs.sv
module adc_cal_regs
    import adc_cal_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         rd,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         busy,
    input  logic         ofs_load,
    input  logic [W-1:0] ofs_val,
    input  logic         gain_load,
    input  logic [W-1:0] gain_val,
    input  logic         finish,
    input  logic         res_valid,
    input  logic [W-1:0] res_data,
    output logic         start,
    output logic [2:0]   cmd_q,
    output logic         bipolar,
    output logic [W-1:0] offset_q,
    output logic [W-1:0] gain_q,
    output logic         done_q
);

    localparam logic [W-1:0] GAIN_ONE = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] data_q;
    logic         cmd_ok;
    logic         wr_idle;
    logic         rd_clears;

    assign cmd_ok    = (wdata[2:0] == CMD_OFS) || (wdata[2:0] == CMD_GAIN) ||
                       (wdata[2:0] == CMD_BOTH);
    assign wr_idle   = wr && !busy;
    assign start     = wr_idle && (addr == A_CFG) && cmd_ok;
    assign rd_clears = rd && ((addr == A_SETUP) || (addr == A_DATA) ||
                              (addr == A_OFS) || (addr == A_GAIN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= CMD_NONE;
            bipolar  <= 1'b0;
            offset_q <= '0;
            gain_q   <= GAIN_ONE;
            data_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            if (start)       cmd_q <= wdata[2:0];
            else if (finish) cmd_q <= CMD_NONE;

            if (finish)         done_q <= 1'b1;
            else if (rd_clears) done_q <= 1'b0;

            if (wr_idle && addr == A_SETUP) bipolar <= wdata[0];

            if (ofs_load)                       offset_q <= ofs_val;
            else if (wr_idle && addr == A_OFS)  offset_q <= wdata;

            if (gain_load)                      gain_q <= gain_val;
            else if (wr_idle && addr == A_GAIN) gain_q <= wdata;

            if (res_valid) data_q <= res_data;
        end
    end

    always_comb begin
        unique case (addr)
            A_CFG:   rdata = {{(W-4){1'b0}}, done_q, cmd_q};
            A_SETUP: rdata = {{(W-1){1'b0}}, bipolar};
            A_DATA:  rdata = data_q;
            A_OFS:   rdata = offset_q;
            A_GAIN:  rdata = gain_q;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/adc_cal_correct.sv
module adc_cal_correct #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic [W-1:0] offset,
    input  logic [W-1:0] gain,
    input  logic         bipolar,
    output logic         res_valid,
    output logic [W-1:0] res_data
);

    localparam int PW = 2 * W + 2;
    localparam logic signed [PW-1:0] HI_LIM = PW'((64'sd1 <<< (W - 1)) - 64'sd1);
    localparam logic signed [PW-1:0] LO_LIM = -PW'(64'sd1 <<< (W - 1));

    logic              v1_q;
    logic signed [W:0] diff_q;
    logic signed [PW-1:0] prod, scaled;
    logic [W-1:0]      sat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q   <= 1'b0;
            diff_q <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid)
                diff_q <= $signed({in_data[W-1], in_data}) - $signed({offset[W-1], offset});
        end
    end

    assign prod   = PW'(diff_q) * PW'($signed({1'b0, gain}));
    assign scaled = prod >>> (W - 1);

    always_comb begin
        if (!bipolar && scaled < 0) sat = '0;
        else if (scaled > HI_LIM)   sat = {1'b0, {(W-1){1'b1}}};
        else if (scaled < LO_LIM)   sat = {1'b1, {(W-1){1'b0}}};
        else                        sat = scaled[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= v1_q;
            if (v1_q) res_data <= sat;
        end
    end

endmodule

// File: rtl/adc_cal_core.sv
module adc_cal_core #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [2:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         conv_strobe,
    input  logic         raw_valid,
    input  logic [W-1:0] raw_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         cal_busy,
    output logic         done_flag
);

    logic         start;
    logic [2:0]   cmd_q;
    logic         bipolar;
    logic [W-1:0] offset_q, gain_q;
    logic         ofs_load, gain_load, cal_finish;
    logic [W-1:0] gain_val;
    logic         take;

    assign take = conv_strobe && raw_valid;

    adc_cal_seq #(.W(W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_cmd  (reg_wdata[2:0]),
        .take       (take),
        .sample     (raw_data),
        .offset_cur (offset_q),
        .busy       (cal_busy),
        .ofs_load   (ofs_load),
        .gain_load  (gain_load),
        .gain_val   (gain_val),
        .finish     (cal_finish)
    );

    adc_cal_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .busy      (cal_busy),
        .ofs_load  (ofs_load),
        .ofs_val   (raw_data),
        .gain_load (gain_load),
        .gain_val  (gain_val),
        .finish    (cal_finish),
        .res_valid (out_valid),
        .res_data  (out_data),
        .start     (start),
        .cmd_q     (cmd_q),
        .bipolar   (bipolar),
        .offset_q  (offset_q),
        .gain_q    (gain_q),
        .done_q    (done_flag)
    );

    adc_cal_correct #(.W(W)) u_corr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (raw_valid),
        .in_data   (raw_data),
        .offset    (offset_q),
        .gain      (gain_q),
        .bipolar   (bipolar),
        .res_valid (out_valid),
        .res_data  (out_data)
    );

endmodule

// File: rtl/adc_cal_chk.sv
module adc_cal_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [2:0] reg_addr,
    input logic       raw_valid,
    input logic       out_valid,
    input logic       out_msb,
    input logic       cal_busy,
    input logic       done_flag,
    input logic [2:0] cmd_q,
    input logic       cal_finish,
    input logic       bipolar
);

    logic clr_addr;
    assign clr_addr = (reg_addr >= 3'd1) && (reg_addr <= 3'd4);

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $fell(cal_busy));

    // R6
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_finish |=> (cmd_q == 3'b000 && done_flag));

    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && clr_addr && !cal_finish) |=> !done_flag);

    // R7
    cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'd0 && done_flag) |=> done_flag);

    // R8
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && reg_wr && reg_addr == 3'd0 && !cal_finish) |=> (cmd_q == $past(cmd_q)));

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |-> ##2 out_valid);

    // R10
    unipolar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(bipolar)) |-> !out_msb);

endmodule

bind adc_cal_core adc_cal_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .raw_valid  (raw_valid),
    .out_valid  (out_valid),
    .out_msb    (out_data[W-1]),
    .cal_busy   (cal_busy),
    .done_flag  (done_flag),
    .cmd_q      (cmd_q),
    .cal_finish (cal_finish),
    .bipolar    (bipolar)
);

// File: tb/tb_adc_cal_core.sv
`timescale 1ns/1ps
module tb_adc_cal_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        conv_strobe = 1'b0, raw_valid = 1'b0;
    logic [23:0] raw_data = '0;
    logic        out_valid;
    logic [23:0] out_data;
    logic        cal_busy, done_flag;

    int n_chk = 0;
    int n_fail = 0;

    longint m_ofs = 0;
    longint m_gain = 64'h800000;
    bit     m_bip = 1'b0;

    always #2.5 clk = ~clk;

    adc_cal_core dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .conv_strobe(conv_strobe), .raw_valid(raw_valid), .raw_data(raw_data),
        .out_valid(out_valid), .out_data(out_data),
        .cal_busy(cal_busy), .done_flag(done_flag)
    );

    function automatic longint sx(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint exp_gain(input longint d);
        if (d < 64'h400000) return 64'hFFFFFF;
        return (((64'sd1 <<< 23) - 1) <<< 23) / d;
    endfunction

    function automatic longint exp_out(input logic [23:0] s);
        longint p;
        p = ((sx(s) - m_ofs) * m_gain) >>> 23;
        if (!m_bip && p < 0) return 0;
        if (p > 64'sd8388607) return 64'sd8388607;
        if (p < -64'sd8388608) return -64'sd8388608;
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [23:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic conv(input logic [23:0] s);
        @(negedge clk);
        conv_strobe = 1'b1; raw_valid = 1'b1; raw_data = s;
        @(negedge clk);
        conv_strobe = 1'b0; raw_valid = 1'b0;
    endtask

    task automatic feed(input logic [23:0] s, input string req);
        longint e;
        e = exp_out(s);
        @(negedge clk);
        raw_valid = 1'b1; raw_data = s;
        @(negedge clk);
        raw_valid = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b1, req, longint'(out_valid), 1);
        chk(sx(out_data) == e, req, sx(out_data), e);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && cal_busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [23:0] d;
        chk(!done_flag && !cal_busy, "R1", {done_flag, cal_busy}, 0);
        rd(3'd0, d); chk(d == 0, "R1", d, 0);
        rd(3'd1, d); chk(d == 0, "R1", d, 0);
        rd(3'd3, d); chk(d == 0, "R1", d, 0);
        rd(3'd4, d); chk(d == 24'h800000, "R1", d, 24'h800000);
    endtask

    task automatic t_pass();
        logic [23:0] d;
        feed(24'h001000, "R9");
        feed(24'hFFF000, "R10 unipolar clamp");
        wr(3'd1, 24'h1); m_bip = 1'b1;
        rd(3'd1, d); chk(d == 1, "R2", d, 1);
        feed(24'hFFF000, "R10 bipolar");
        rd(3'd2, d); chk(d == 24'hFFF000, "R11", d, 24'hFFF000);
    endtask

    task automatic t_bad_cmd();
        logic [23:0] d;
        wr(3'd0, 24'h4);
        chk(!cal_busy, "R8 code 100", cal_busy, 0);
        rd(3'd0, d); chk(d[2:0] == 0, "R8", d, 0);
        wr(3'd0, 24'h0);
        chk(!cal_busy, "R8 code 000", cal_busy, 0);
    endtask

    task automatic t_offset();
        logic [23:0] d;
        wr(3'd0, 24'h1);
        chk(cal_busy, "R3 busy", cal_busy, 1);
        rd(3'd0, d); chk(d == 24'h1, "R2 cmd visible", d, 1);
        conv(24'h000123);
        wait_idle();
        m_ofs = 64'h123;
        chk(done_flag, "R6 done", done_flag, 1);
        rd(3'd0, d); chk(d == 24'h8, "R6 cmd cleared", d, 8);
        chk(done_flag, "R7 cfg read keeps", done_flag, 1);
        rd(3'd3, d); chk(d == 24'h000123, "R3 offset", d, 24'h123);
        chk(!done_flag, "R7 offset read clears", done_flag, 0);
    endtask

    task automatic t_gain();
        logic [23:0] d;
        wr(3'd0, 24'h2);
        conv(24'h600123);
        wait_idle();
        m_gain = exp_gain(sx(24'h600123) - m_ofs);
        chk(done_flag, "R4 done", done_flag, 1);
        rd(3'd4, d); chk(longint'(d) == m_gain, "R4 gain", d, m_gain);
        chk(!done_flag, "R7 gain read clears", done_flag, 0);
    endtask

    task automatic t_correct();
        feed(24'h600123, "R9 full scale");
        feed(24'h000123, "R9 zero");
        feed(24'h7FFFFF, "R10 pos sat");
        feed(24'h800000, "R10 neg sat");
        feed(24'h200000, "R9 mid");
        feed(24'hE00000, "R9 negative");
    endtask

    task automatic t_both();
        logic [23:0] d;
        wr(3'd0, 24'h3);
        conv(24'h000200);
        repeat (3) @(negedge clk);
        chk(cal_busy && !done_flag, "R5 between steps", {cal_busy, done_flag}, 2);
        conv(24'h500200);
        wait_idle();
        m_ofs = 64'h200;
        m_gain = exp_gain(64'h500000);
        chk(done_flag, "R5 done", done_flag, 1);
        rd(3'd3, d); chk(d == 24'h000200, "R5 offset", d, 24'h200);
        rd(3'd4, d); chk(longint'(d) == m_gain, "R5 gain", d, m_gain);
    endtask

    task automatic t_busy_wr();
        logic [23:0] d;
        wr(3'd0, 24'h1);
        wr(3'd0, 24'h2);
        wr(3'd4, 24'h123456);
        rd(3'd0, d); chk(d[2:0] == 3'd1, "R8 busy write", d, 1);
        conv(24'h000050);
        wait_idle();
        m_ofs = 64'h50;
        repeat (3) @(negedge clk);
        chk(!cal_busy, "R8 no second run", cal_busy, 0);
        rd(3'd3, d); chk(d == 24'h50, "R8 offset", d, 24'h50);
        rd(3'd4, d); chk(longint'(d) == m_gain, "R2 gain write ignored when busy", d, m_gain);
    endtask

    task automatic t_gain_sat();
        logic [23:0] d;
        wr(3'd0, 24'h2);
        conv(24'h000150);
        wait_idle();
        rd(3'd4, d); chk(d == 24'hFFFFFF, "R4 small divisor", d, 24'hFFFFFF);
        wr(3'd0, 24'h2);
        conv(24'hFF0000);
        wait_idle();
        rd(3'd4, d); chk(d == 24'hFFFFFF, "R4 negative divisor", d, 24'hFFFFFF);
        m_gain = 64'hFFFFFF;
        wr(3'd0, 24'h2);
        conv(24'h400050);
        wait_idle();
        m_gain = exp_gain(64'h400000);
        rd(3'd4, d); chk(longint'(d) == m_gain, "R4 min divisor", d, m_gain);
    endtask

    task automatic t_clear_each();
        logic [23:0] d;
        logic [2:0] addrs [4] = '{3'd1, 3'd2, 3'd4, 3'd3};
        for (int i = 0; i < 4; i++) begin
            wr(3'd0, 24'h1);
            conv(24'h000050);
            wait_idle();
            rd(3'd0, d);
            chk(done_flag, "R7 cfg read", done_flag, 1);
            rd(addrs[i], d);
            chk(!done_flag, "R7 clear by addr", addrs[i], 0);
        end
        m_ofs = 64'h50;
    endtask

    task automatic t_direct();
        wr(3'd3, 24'h000100); m_ofs = 64'h100;
        wr(3'd4, 24'h400000); m_gain = 64'h400000;
        feed(24'h000300, "R2 direct write");
        feed(24'hFFFF00, "R2 direct write neg");
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_bad_cmd();
        t_offset();
        t_gain();
        t_correct();
        t_both();
        t_busy_wr();
        t_gain_sat();
        t_clear_each();
        t_direct();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule